// File: doc/BRIEF.md
# Multithread Issue Hole Scheduler

This block sits in the issue stage of a single-issue, in-order pipeline that runs several hardware threads against one register-file write port. An ordinary operation writes that port a fixed number of cycles after it issues, so two ordinary operations can never meet there. A slow special-register read, by contrast, returns its data through the same write path noticeably later. Left alone, its write can land in the same cycle as the write of an ordinary operation that another thread issued after it.

The scheduler prevents that collision in two ways. First, it holds back the thread that issued the slow read until a completion pulse for that thread arrives. Second, it counts a programmable delay from the slow issue and then blanks one issue slot for every thread. The late result therefore finds the write port free. Each slow issue books its own blank slot in a small pending-hole shift register, so requests that overlap are never merged. A per-thread flush drops a thread's stall, but any hole already booked stays booked. A collision flag shows when a completion pulse falls in the same cycle as an ordinary writeback. A bench can use it to show that a wrong delay setting is caught.

Each thread offers one instruction as a valid/ready pair. The instruction is taken in a cycle where its ready is high, and it must be held until then. Ready may depend on valid. Ready is low while a hole is being forced, while the thread is stalled, and while a lower-numbered thread is taking the slot.

Top module: `issue_hole_sched`

## Requirements
- R1: In each cycle with no forced hole, the lowest-numbered thread that has valid high and is not stalled is granted. Only that thread's ready goes high, iss_vld_o is high, and iss_tid_o carries its binary index. When no thread is eligible, iss_vld_o is low.
- R2: A thread whose granted instruction has its slow flag high gets ready held low from the next cycle. The hold lasts until the cycle after slow_done_i is pulsed with slow_done_tid_i equal to that thread. A pulse that carries another thread's index leaves the hold in place.
- R3: While one thread is held by R2, the other threads keep being granted under R1.
- R4: A slow issue in cycle c forces a hole in cycle c+D, where D is the delay register, with 0 treated as 1. In the hole cycle hole_o is high, iss_vld_o is low and every ready is low.
- R5: The delay register resets to 7. A write with cfg_we_i loads cfg_dly_i, and the new value applies to slow issues from the next cycle onward.
- R6: Slow issues in different cycles each get their own hole, even when their delay windows overlap.
- R7: Asserting flush_i for a thread clears that thread's hold from the next cycle. A hole already booked by that thread still occurs.
- R8: An ordinary (non-slow) issue in cycle c counts as a writeback in cycle c+NORM_LAT. coll_o is high in any cycle where slow_done_i is high and such a writeback falls in the same cycle.
- R9: During reset no thread is held, no hole is pending, and hole_o and coll_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_vld_i | input | NTHR | Per-thread instruction valid |
| thr_slow_i | input | NTHR | Per-thread flag: the offered instruction is a slow read |
| thr_rdy_o | output | NTHR | Per-thread ready (grant) |
| iss_vld_o | output | 1 | An instruction issues this cycle |
| iss_tid_o | output | TID_W | Index of the issuing thread |
| iss_slow_o | output | 1 | The issuing instruction is a slow read |
| slow_done_i | input | 1 | Slow-read result is being written this cycle |
| slow_done_tid_i | input | TID_W | Thread that owns the completing slow read |
| flush_i | input | NTHR | Per-thread flush, cancels a pending hold |
| cfg_we_i | input | 1 | Load strobe for the hole delay |
| cfg_dly_i | input | DLY_W | New hole delay in cycles |
| hole_o | output | 1 | Forced empty issue slot this cycle |
| coll_o | output | 1 | Slow writeback meets an ordinary writeback |

## Verification
With both threads offering ordinary work, the bench tests priority and shows that grants follow eligibility alone. It then runs a slow read on one thread while the other keeps issuing. This separates the per-thread hold from the global hole and shows where the hole lands relative to the completion pulse. Running the same stream with the delay set to 5 and then to 0 tells a correct delay from a short one, since only the short one raises the collision flag, and it also covers the zero clamp. Back-to-back slow reads on both threads separate one hole per request from merged holes. A wrong-thread completion followed by a flush shows that a flush frees the thread without cancelling the hole it booked.

// File: rtl/ihs_pkg.sv
package ihs_pkg;
  localparam int unsigned DLY_W_DEF    = 5;
  localparam int unsigned DLY_RST_DEF  = 7;
  localparam int unsigned NORM_LAT_DEF = 6;
endpackage

// File: rtl/ihs_arb.sv
module ihs_arb #(
  parameter int unsigned NTHR  = 2,
  parameter int unsigned TID_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTHR-1:0]  elig_i,
  input  logic             block_i,
  output logic [NTHR-1:0]  gnt_o,
  output logic [TID_W-1:0] tid_o
);
  // fixed priority, lowest index first; a forced hole blanks the slot
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    tid_o = '0;
    for (int i = 0; i < int'(NTHR); i++) begin
      if (elig_i[i] && !found && !block_i) begin
        gnt_o[i] = 1'b1;
        tid_o    = TID_W'(i);
        found    = 1'b1;
      end
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_o));
  p_legal_r1:  assert property (@(posedge clk) disable iff (!rst_n) (gnt_o & ~elig_i) == '0);
  p_work_r1:   assert property (@(posedge clk) disable iff (!rst_n) (|elig_i && !block_i) |-> |gnt_o);
  p_block_r4:  assert property (@(posedge clk) disable iff (!rst_n) block_i |-> gnt_o == '0);
endmodule

// File: rtl/ihs_hole_pipe.sv
module ihs_hole_pipe #(
  parameter int unsigned DLY_W   = 5,
  parameter int unsigned DLY_RST = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [DLY_W-1:0] cfg_dly_i,
  input  logic             req_i,
  output logic             hole_o
);
  localparam int unsigned DEPTH = (1 << DLY_W) - 1;

  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] slot_idx;
  logic [DEPTH-1:0] pend_q, pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dly_q <= DLY_W'(DLY_RST);
    else if (cfg_we_i) dly_q <= cfg_dly_i;
  end

  // a delay of zero behaves as one
  assign slot_idx = (dly_q == '0) ? '0 : dly_q - 1'b1;

  // each bit is one booked hole; bit 0 is the current cycle
  always_comb begin
    pend_d = pend_q >> 1;
    if (req_i) pend_d[slot_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign hole_o = pend_q[0];

  p_rst_dly_r5: assert property (@(posedge clk) $rose(rst_n) |-> dly_q == DLY_W'(DLY_RST));
  p_book_r6:    assert property (@(posedge clk) disable iff (!rst_n) req_i |=> pend_q[$past(slot_idx)]);
  p_min_r4:     assert property (@(posedge clk) disable iff (!rst_n) (req_i && slot_idx == '0) |=> hole_o);
endmodule

// File: rtl/ihs_wb_track.sv
module ihs_wb_track #(
  parameter int unsigned LAT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic norm_iss_i,
  input  logic slow_wb_i,
  output logic coll_o
);
  logic norm_wb;

  generate
    if (LAT == 1) begin : g_one
      logic wb_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wb_q <= 1'b0;
        else        wb_q <= norm_iss_i;
      end
      assign norm_wb = wb_q;
    end else begin : g_pipe
      logic [LAT-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[LAT-2:0], norm_iss_i};
      end
      assign norm_wb = sh_q[LAT-1];
    end
  endgenerate

  assign coll_o = norm_wb & slow_wb_i;
endmodule

// File: rtl/issue_hole_sched.sv
module issue_hole_sched
  import ihs_pkg::*;
#(
  parameter int unsigned NTHR     = 2,
  parameter int unsigned NORM_LAT = NORM_LAT_DEF,
  parameter int unsigned DLY_W    = DLY_W_DEF,
  parameter int unsigned DLY_RST  = DLY_RST_DEF,
  localparam int unsigned TID_W   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTHR-1:0]  thr_vld_i,
  input  logic [NTHR-1:0]  thr_slow_i,
  output logic [NTHR-1:0]  thr_rdy_o,
  output logic             iss_vld_o,
  output logic [TID_W-1:0] iss_tid_o,
  output logic             iss_slow_o,
  input  logic             slow_done_i,
  input  logic [TID_W-1:0] slow_done_tid_i,
  input  logic [NTHR-1:0]  flush_i,
  input  logic             cfg_we_i,
  input  logic [DLY_W-1:0] cfg_dly_i,
  output logic             hole_o,
  output logic             coll_o
);
  logic [NTHR-1:0] stall_q, elig, gnt, hreq;
  logic            hole_now, norm_iss;

  assign elig = thr_vld_i & ~stall_q;

  ihs_arb #(.NTHR(NTHR), .TID_W(TID_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig_i(elig), .block_i(hole_now),
    .gnt_o(gnt), .tid_o(iss_tid_o)
  );

  generate
    for (genvar t = 0; t < int'(NTHR); t++) begin : g_thr
      logic stall_r, done_hit;
      assign done_hit = slow_done_i && (slow_done_tid_i == TID_W'(t));
      assign hreq[t]  = gnt[t] & thr_slow_i[t];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      stall_r <= 1'b0;
        else if (flush_i[t] || done_hit) stall_r <= 1'b0;
        else if (hreq[t])                stall_r <= 1'b1;
      end
      assign stall_q[t] = stall_r;

      p_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stall_r |-> !thr_rdy_o[t]);
      p_hold_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hreq[t] && !flush_i[t] && !done_hit) |=> !thr_rdy_o[t]);
      p_rst_free_r9: assert property (@(posedge clk)
        $rose(rst_n) |-> !stall_r);
    end
  endgenerate

  ihs_hole_pipe #(.DLY_W(DLY_W), .DLY_RST(DLY_RST)) u_hole (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_dly_i(cfg_dly_i),
    .req_i(|hreq), .hole_o(hole_now)
  );

  assign thr_rdy_o  = gnt;
  assign iss_vld_o  = |gnt;
  assign iss_slow_o = |hreq;
  assign hole_o     = hole_now;
  assign norm_iss   = iss_vld_o & ~iss_slow_o;

  ihs_wb_track #(.LAT(NORM_LAT)) u_wb (
    .clk(clk), .rst_n(rst_n), .norm_iss_i(norm_iss),
    .slow_wb_i(slow_done_i), .coll_o(coll_o)
  );

  p_hole_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hole_o |-> (!iss_vld_o && thr_rdy_o == '0));
  p_coll_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    coll_o |-> slow_done_i);
endmodule

// File: tb/issue_hole_sched_tb.sv
module issue_hole_sched_tb;
  localparam int NT = 2;
  localparam int L  = 6;
  localparam int DW = 5;
  localparam int TW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT-1:0] thr_vld_i, thr_slow_i, thr_rdy_o, flush_i;
  logic iss_vld_o, iss_slow_o, slow_done_i, cfg_we_i, hole_o, coll_o;
  logic [TW-1:0] iss_tid_o, slow_done_tid_i;
  logic [DW-1:0] cfg_dly_i;

  always #4 clk = ~clk;

  issue_hole_sched #(.NTHR(NT), .NORM_LAT(L), .DLY_W(DW), .DLY_RST(7)) u_dut (
    .clk(clk), .rst_n(rst_n), .thr_vld_i(thr_vld_i), .thr_slow_i(thr_slow_i),
    .thr_rdy_o(thr_rdy_o), .iss_vld_o(iss_vld_o), .iss_tid_o(iss_tid_o),
    .iss_slow_o(iss_slow_o), .slow_done_i(slow_done_i),
    .slow_done_tid_i(slow_done_tid_i), .flush_i(flush_i), .cfg_we_i(cfg_we_i),
    .cfg_dly_i(cfg_dly_i), .hole_o(hole_o), .coll_o(coll_o)
  );

  typedef struct {
    logic          vld;
    logic [TW-1:0] tid;
    logic [NT-1:0] rdy;
    logic          hole;
    logic          coll;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit fin = 0;
  logic [NT-1:0] stall_m;
  bit hole_at[int];
  bit wb_at[int];
  int dcfg_m, k;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic tick(logic [NT-1:0] v, logic [NT-1:0] s, logic dn, logic [TW-1:0] dt,
                      logic [NT-1:0] fl, logic we, logic [DW-1:0] wd, string tag);
    exp_t e;
    logic [NT-1:0] g;
    int eff;
    @(negedge clk);
    thr_vld_i = v; thr_slow_i = s; slow_done_i = dn; slow_done_tid_i = dt;
    flush_i = fl; cfg_we_i = we; cfg_dly_i = wd;
    e.hole = hole_at.exists(k);
    g = '0;
    if (!e.hole)
      for (int t = 0; t < NT; t++)
        if (v[t] && !stall_m[t] && g == '0) g[t] = 1'b1;
    e.rdy = g; e.vld = |g; e.tid = '0;
    for (int t = 0; t < NT; t++) if (g[t]) e.tid = TW'(t);
    e.coll = dn && wb_at.exists(k);
    e.tag = tag;
    q.push_back(e);
    eff = (dcfg_m == 0) ? 1 : dcfg_m;
    for (int t = 0; t < NT; t++) begin
      bit clr;
      clr = fl[t] || (dn && dt == TW'(t));
      if (clr) stall_m[t] = 1'b0;
      else if (g[t] && s[t]) stall_m[t] = 1'b1;
      if (g[t] && s[t])  hole_at[k + eff] = 1'b1;
      if (g[t] && !s[t]) wb_at[k + L] = 1'b1;
    end
    if (we) dcfg_m = int'(wd);
    k++;
  endtask

  task automatic run(logic [NT-1:0] v, logic [NT-1:0] s, string tag);
    tick(v, s, 1'b0, '0, '0, 1'b0, '0, tag);
  endtask

  task automatic done(logic [NT-1:0] v, logic [TW-1:0] dt, string tag);
    tick(v, '0, 1'b1, dt, '0, 1'b0, '0, tag);
  endtask

  task automatic setdly(logic [DW-1:0] d, string tag);
    tick('0, '0, 1'b0, '0, '0, 1'b1, d, tag);
  endtask

  // monitor: pops one expectation per driven cycle and compares
  always @(negedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(iss_vld_o === e.vld, {"R1 ", e.tag}, "iss_vld", iss_vld_o, e.vld);
      if (e.vld) chk(iss_tid_o === e.tid, {"R1 ", e.tag}, "iss_tid", iss_tid_o, e.tid);
      chk(thr_rdy_o === e.rdy, {"R2 ", e.tag}, "thr_rdy", thr_rdy_o, e.rdy);
      chk(hole_o === e.hole, {"R4 ", e.tag}, "hole", hole_o, e.hole);
      chk(coll_o === e.coll, {"R8 ", e.tag}, "coll", coll_o, e.coll);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    thr_vld_i = 2'b11; thr_slow_i = '0; slow_done_i = 0; slow_done_tid_i = '0;
    flush_i = '0; cfg_we_i = 0; cfg_dly_i = '0;
    stall_m = '0; dcfg_m = 7; k = 0;
    repeat (3) @(posedge clk);
    #1;
    // R9: in reset nothing is held or pending
    chk(hole_o === 1'b0, "R9", "hole in reset", hole_o, 0);
    chk(coll_o === 1'b0, "R9", "coll in reset", coll_o, 0);
    chk(thr_rdy_o === 2'b01, "R9", "rdy in reset", thr_rdy_o, 2'b01);
    @(negedge clk);
    rst_n = 1'b1; thr_vld_i = '0;

    run(2'b00, 2'b00, "R9 idle");
    run(2'b00, 2'b00, "R9 idle");
    // R1 priority
    run(2'b11, 2'b00, "R1 both");
    run(2'b11, 2'b00, "R1 both");
    run(2'b10, 2'b00, "R1 t1 only");
    run(2'b00, 2'b00, "R1 none");
    for (int i = 0; i < 8; i++) run(2'b00, 2'b00, "R1 drain");

    // R2 R3 R4: slow on t0, t1 keeps issuing, hole at +7, done aligned
    run(2'b01, 2'b01, "R2 slow t0");
    for (int i = 1; i < 16; i++) begin
      if (i == 13) done(2'b11, 1'b0, "R2 R4 aligned done");
      else         run(2'b11, 2'b00, "R3 t1 streams");
    end

    // R5 R8: short delay leaves a collision
    setdly(5'd5, "R5 load 5");
    run(2'b01, 2'b01, "R5 slow t0 d5");
    for (int i = 1; i < 15; i++) begin
      if (i == 13) done(2'b10, 1'b0, "R8 short delay collides");
      else         run(2'b10, 2'b00, "R8 t1 streams");
    end
    // R5: zero acts as one
    setdly(5'd0, "R5 load 0");
    run(2'b01, 2'b01, "R5 slow t0 d0");
    run(2'b10, 2'b00, "R5 hole next cycle");
    run(2'b10, 2'b00, "R5 after hole");
    done(2'b00, 1'b0, "R5 release");
    for (int i = 0; i < 8; i++) run(2'b00, 2'b00, "R5 drain");
    setdly(5'd7, "R5 restore 7");

    // R6: overlapping windows, two separate holes
    run(2'b01, 2'b01, "R6 slow t0");
    run(2'b10, 2'b10, "R6 slow t1");
    for (int i = 2; i < 13; i++) begin
      if (i == 9)       done(2'b11, 1'b0, "R6 done t0");
      else if (i == 11) done(2'b11, 1'b1, "R6 done t1");
      else              run(2'b11, 2'b00, "R6 window");
    end

    // R7 and R2 wrong-thread done
    run(2'b01, 2'b01, "R7 slow t0");
    done(2'b01, 1'b1, "R2 wrong tid keeps hold");
    tick(2'b01, 2'b00, 1'b0, '0, 2'b01, 1'b0, '0, "R7 flush t0");
    for (int i = 3; i < 11; i++) run(2'b01, 2'b00, "R7 booked hole stays");
    for (int i = 0; i < 8; i++) run(2'b00, 2'b00, "R9 final idle");

    @(negedge clk);
    #3;
    chk(q.size() == 0, "R1", "scoreboard drained", q.size(), 0);
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule